// File: doc/BRIEF.md
# Guarded Correction-Value Write Gate

This block holds two correction values for a slow real-time-clock domain: an offset trim and a temperature trim. Software writes them from the fast bus clock. The block takes a write only when it is free to move a new value into the slow domain, and it drops the write otherwise.

Two status outputs report on the writes. `ready` shows whether the gate is free. `ok` shows whether the latest write attempt was taken. After a write is taken, the new value is handed to the slow clock through a toggle request and a toggle acknowledge, each passed through a two-flop synchronizer. `ready` stays low until the acknowledge has come back.

Both values share one `ready` flag and one `ok` flag. A transfer in flight for either value therefore blocks writes to both. The bus-side copies of both values can be read at any time.

Top module: `trim_write_gate`

## Requirements
- R1: After reset `ready` is 1, `ok` is 0, and `offset_q`, `temp_q`, `slow_offset` and `slow_temp` are all zero.
- R2: A write (`wr_en`=1) made while `ready` is 1 loads `wr_data` into the selected value on the next bus clock edge. `wr_sel`=0 selects the offset value and `wr_sel`=1 selects the temperature value. The other value is left unchanged.
- R3: A write made while `ready` is 0 leaves both `offset_q` and `temp_q` unchanged.
- R4: `ok` becomes 1 on the bus edge that takes a write, and becomes 0 on the bus edge of a write made while `ready` is 0.
- R5: On cycles with no write attempt, `ok` keeps its value.
- R6: `ready` is 0 in the cycle after a taken write and stays 0 while that transfer is pending. With no transfer pending, `ready` is 1.
- R7: Whenever `ready` is 1, `slow_offset` equals `offset_q` and `slow_temp` equals `temp_q`.
- R8: `ready` returns to 1 within 40 bus cycles of a taken write when the slow clock is at most 7 times slower than the bus clock.
- R9: While a transfer of either value is pending, writes to both values are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain reset, active low |
| slow_clk | input | 1 | Slow real-time-clock domain clock |
| slow_rst_n | input | 1 | Slow-domain reset, active low |
| wr_en | input | 1 | Write attempt strobe, one per cycle |
| wr_sel | input | 1 | 0 selects offset value, 1 selects temperature value |
| wr_data | input | W | Value to write |
| ready | output | 1 | Gate free to take a write |
| ok | output | 1 | Latest write attempt was taken |
| offset_q | output | W | Bus-side offset value |
| temp_q | output | W | Bus-side temperature value |
| slow_offset | output | W | Offset value in the slow domain |
| slow_temp | output | W | Temperature value in the slow domain |

## Verification
The assertions assume three things about the inputs. Both resets are asserted together. The slow clock keeps running, so every transfer completes. `wr_data` and `wr_sel` are only meaningful on a cycle with `wr_en` high. The R7 check, made in the bus domain, relies on the slow copies changing only while `ready` is low. The stimulus asserts both resets at once, runs the slow clock at seven bus periods with an unrelated phase, and drives all inputs on falling bus edges. It also fires many writes into pending transfers to exercise the reject path.

// File: rtl/trim_write_gate.sv
module trim_write_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slow_clk,
  input  logic         slow_rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         ready,
  output logic         ok,
  output logic [W-1:0] offset_q,
  output logic [W-1:0] temp_q,
  output logic [W-1:0] slow_offset,
  output logic [W-1:0] slow_temp
);

  logic busy, take;
  logic req_t, ack_m, ack_s;
  logic req_m, req_s, ack_t;

  assign take  = wr_en & ~busy;
  assign ready = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ok       <= 1'b0;
      req_t    <= 1'b0;
      ack_m    <= 1'b0;
      ack_s    <= 1'b0;
      offset_q <= '0;
      temp_q   <= '0;
    end else begin
      ack_m <= ack_t;
      ack_s <= ack_m;
      if (wr_en) ok <= take;
      if (take) begin
        if (wr_sel) temp_q   <= wr_data;
        else        offset_q <= wr_data;
        req_t <= ~req_t;
        busy  <= 1'b1;
      end else if (busy && (ack_s == req_t)) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      req_m       <= 1'b0;
      req_s       <= 1'b0;
      ack_t       <= 1'b0;
      slow_offset <= '0;
      slow_temp   <= '0;
    end else begin
      req_m <= req_t;
      req_s <= req_m;
      if (req_s != ack_t) begin
        slow_offset <= offset_q;
        slow_temp   <= temp_q;
        ack_t       <= req_s;
      end
    end
  end

endmodule

// File: rtl/trim_write_gate_chk.sv
module trim_write_gate_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic         ready,
  input logic         ok,
  input logic [W-1:0] offset_q,
  input logic [W-1:0] temp_q,
  input logic [W-1:0] slow_offset,
  input logic [W-1:0] slow_temp
);

  // R2
  offset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready && !wr_sel) |=> (offset_q == $past(wr_data)) && $stable(temp_q));

  // R2
  temp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready && wr_sel) |=> (temp_q == $past(wr_data)) && $stable(offset_q));

  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready) |=> $stable(offset_q) && $stable(temp_q));

  // R4
  ok_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready) |=> ok);

  // R4
  ok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready) |=> !ok);

  // R5
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ok));

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready) |=> !ready);

  // R7
  slow_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (slow_offset == offset_q) && (slow_temp == temp_q));

endmodule

bind trim_write_gate trim_write_gate_chk #(.W(W)) u_chk (.*);

// File: tb/test_trim_write_gate.sv
module test_trim_write_gate;
  localparam int W = 16;
  localparam int BOUND = 40;

  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0, slow_rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic ready, ok;
  logic [W-1:0] offset_q, temp_q, slow_offset, slow_temp;

  trim_write_gate #(.W(W)) i_trim_write_gate (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ready(ready), .ok(ok), .offset_q(offset_q), .temp_q(temp_q),
    .slow_offset(slow_offset), .slow_temp(slow_temp));

  always #5 clk = ~clk;
  initial begin #3; forever #35 slow_clk = ~slow_clk; end

  int checks = 0, failures = 0, cycles = 0, lat = 0;
  bit m_ok = 0, expect_fall = 0, pending = 0, done = 0;
  logic [W-1:0] m_off = '0, m_tmp = '0;
  int seed = 12345;

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic compare();
    chk(ok == m_ok, "R4/R5 ok", ok, m_ok);
    chk(offset_q == m_off, "R2/R3 offset_q", offset_q, m_off);
    chk(temp_q == m_tmp, "R2/R3 temp_q", temp_q, m_tmp);
    if (expect_fall) begin
      chk(ready == 1'b0, "R6 ready low after take", ready, 0);
      expect_fall = 0;
      pending = 1;
      lat = 1;
    end else if (pending) begin
      if (ready) begin
        chk(slow_offset == m_off, "R7 slow_offset", slow_offset, m_off);
        chk(slow_temp == m_tmp, "R7 slow_temp", slow_temp, m_tmp);
        chk(lat <= BOUND, "R8 ready latency", lat, BOUND);
        pending = 0;
      end else begin
        lat++;
        if (lat > BOUND) begin
          chk(1'b0, "R8 ready latency", lat, BOUND);
          pending = 0;
        end
      end
    end else begin
      chk(ready == 1'b1, "R6 ready idle", ready, 1);
      chk(slow_offset == m_off && slow_temp == m_tmp, "R7 slow idle",
          {slow_offset, slow_temp}, {m_off, m_tmp});
    end
  endtask

  task automatic cyc(input bit en, input bit sel, input logic [W-1:0] d);
    @(negedge clk);
    compare();
    wr_en = en; wr_sel = sel; wr_data = d;
    if (en) begin
      if (ready) begin
        if (sel) m_tmp = d; else m_off = d;
        m_ok = 1;
        expect_fall = 1;
      end else begin
        m_ok = 0;
      end
    end
  endtask

  task automatic idle_until_ready();
    for (int i = 0; i < 60; i++) begin
      cyc(0, 0, '0);
      if (ready && !pending && !expect_fall) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(ok == 1'b0, "R1 ok", ok, 0);
    chk(offset_q == 0 && temp_q == 0, "R1 values", {offset_q, temp_q}, 0);
    chk(slow_offset == 0 && slow_temp == 0, "R1 slow", {slow_offset, slow_temp}, 0);
    rst_n = 1'b1; slow_rst_n = 1'b1;
    repeat (4) cyc(0, 0, '0);

    // R2 offset write, R9 temp write blocked while pending
    cyc(1, 0, 16'h5A5A);
    cyc(1, 1, 16'h1234);
    cyc(0, 0, '0);
    // R5 ok holds
    repeat (3) cyc(0, 0, '0);
    idle_until_ready();
    // R2 temp write, R3 repeated rejects
    cyc(1, 1, 16'hBEEF);
    repeat (5) cyc(1, 0, 16'hFFFF);
    idle_until_ready();
    // R4 ok recovers after accepted write
    cyc(1, 0, 16'h0001);
    idle_until_ready();
    cyc(1, 1, 16'h0000);
    idle_until_ready();

    for (int n = 0; n < 3000; n++) begin
      seed = seed * 1103515245 + 12345;
      cyc(seed[20:18] == 3'd0, seed[9], seed[31:16]);
    end
    idle_until_ready();
    repeat (4) cyc(0, 0, '0);
    finish_run();
  end
endmodule